// File: doc/BRIEF.md
# Per-Key Touch Detection Engine

This block decides, key by key, whether a capacitive matrix key is being touched. Each valid cycle brings one 8-bit conversion result for one key, together with that key's setup values and the global hysteresis codes. The engine keeps a small per-key record: reference level, confirmation count, detect flag, drift-rate counter and two recalibration timers. It updates only the record of the indexed key, so a full scan of the matrix takes one valid cycle per key.

A touch lowers the signal. The engine confirms it with an up/down/clear integrator against a threshold set below the reference, and a hysteresis band delays the release. The reference follows slow drift at separate rising and falling rates, and only while the key is idle. The reference snaps to the signal after a detection lasts too long, or after the signal stays high above the reference for too long. Two boundary flags per key report a reference that has moved close to either end of the window. A synchronous calibrate request re-seeds the indexed key from its current sample.

Top module: `touch_key_engine`

## Requirements
- R1: After reset every reference is 128, and all detect and error bits are 0.
- R2: Let d = reference − sample. A sample is beyond threshold when d ≥ neg_thr_i. It is inside the hysteresis band when d ≥ neg_thr_i − (neg_thr_i >> s), where the hysteresis code 0 gives s=3 (12.5%), 1 gives s=2 (25%), and 2 or 3 give s=1 (50%). The positive side uses −d, pos_thr_i and pos_hys_i in the same way.
- R3: While a key is not detected, a beyond-threshold sample increments its count. The detect bit sets on the sample that brings the count to di_lim_i.
- R4: While a key is not detected, a sample inside the hysteresis band but not beyond threshold decrements the count, saturating at 0. A sample outside the band clears the count.
- R5: While a key is detected, a sample inside the band reloads the count to di_lim_i. A sample outside the band decrements the count, and the detect bit clears on the sample that takes the count to 0. With di_lim_i = 0 the key never detects.
- R6: Drift applies only to samples where the key is neither detected before nor after the sample. Each such sample above or below the reference advances a per-key counter. When the counter reaches rate_up_i (signal above) or rate_dn_i (signal below), the reference steps 1 LSB toward the signal and the counter restarts. A rate of 0 disables that direction.
- R7: On the neg_dly_i-th consecutive sample that finds the key already detected, the reference is set to the sample and the detect bit and count clear. A delay of 0 disables this.
- R8: A sample beyond the positive threshold advances the positive timer. A sample inside the positive band but not beyond the threshold holds it, and any other sample clears it. When the timer reaches pos_dly_i, the reference is set to the sample. A delay of 0 disables this.
- R9: err_hi_o[k] is 1 exactly when reference k > 191, and err_lo_o[k] is 1 exactly when reference k < 64. Neither bit causes any recalibration.
- R10: A valid sample with cal_i = 1 sets the indexed reference to the sample and clears that key's detect bit, count, drift counter and timers.
- R11: Only the indexed key's state changes on a valid sample. Nothing changes without a valid sample.
- R12: ref_o shows, combinationally, the stored reference of the key selected by key_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample valid for key_idx_i |
| key_idx_i | input | 6 | Key being sampled / read |
| smp_i | input | 8 | Conversion result |
| cal_i | input | 1 | Re-seed indexed key from sample |
| neg_thr_i | input | 8 | Per-key negative threshold |
| pos_thr_i | input | 8 | Per-key positive threshold |
| neg_hys_i | input | 2 | Global negative hysteresis code |
| pos_hys_i | input | 2 | Global positive hysteresis code |
| di_lim_i | input | 4 | Per-key confirmation limit, 0 disables |
| rate_up_i | input | 8 | Samples per rising drift step, 0 disables |
| rate_dn_i | input | 8 | Samples per falling drift step, 0 disables |
| neg_dly_i | input | 8 | Detection-lasting snap delay, 0 disables |
| pos_dly_i | input | 8 | Positive snap delay, 0 disables |
| det_o | output | 64 | Detect bit per key |
| err_hi_o | output | 64 | Reference above upper boundary, per key |
| err_lo_o | output | 64 | Reference below lower boundary, per key |
| ref_o | output | 8 | Reference of key_idx_i |

## Verification
Two functions can land on the same sample: confirmation of a touch and a falling drift step. With a falling rate of 1 and a confirmation limit of 1, a single deep sample both completes the count and would, on a drift-only view, pull the reference down. The bench drives that sample and expects the detect bit set with the reference still at 128, and it expects the reference unchanged on the following detected sample. The positive snap is also driven on a key whose error flag depends on the snapped value, so the snap and the boundary flag are judged on the same edge.

// File: rtl/tke_pkg.sv
package tke_pkg;
  typedef enum logic [1:0] {
    HYS_EIGHTH = 2'd0,
    HYS_QUARTER = 2'd1,
    HYS_HALF = 2'd2,
    HYS_HALF_ALT = 2'd3
  } hys_e;

  function automatic logic [1:0] hys_shift(input logic [1:0] code);
    case (hys_e'(code))
      HYS_EIGHTH:  return 2'd3;
      HYS_QUARTER: return 2'd2;
      default:     return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/tke_level.sv
module tke_level #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] nthr_i,
  input  logic [DW-1:0] pthr_i,
  input  logic [1:0]    nhys_i,
  input  logic [1:0]    phys_i,
  output logic          below_thr_o,
  output logic          below_hys_o,
  output logic          above_thr_o,
  output logic          above_hys_o
);
  localparam int SW = DW + 2;

  logic signed [SW-1:0] dn, dp, nt, nh, pt, ph;
  logic [DW-1:0] namt, pamt;

  always_comb begin
    namt = nthr_i >> tke_pkg::hys_shift(nhys_i);
    pamt = pthr_i >> tke_pkg::hys_shift(phys_i);
    dn = $signed({2'b00, ref_i}) - $signed({2'b00, smp_i});
    dp = -dn;
    nt = $signed({2'b00, nthr_i});
    pt = $signed({2'b00, pthr_i});
    nh = nt - $signed({2'b00, namt});
    ph = pt - $signed({2'b00, pamt});
    below_thr_o = dn >= nt;
    below_hys_o = dn >= nh;
    above_thr_o = dp >= pt;
    above_hys_o = dp >= ph;
  end
endmodule

// File: rtl/tke_next.sv
module tke_next #(
  parameter int DW  = 8,
  parameter int DIW = 4,
  parameter int TW  = 8
) (
  input  logic           cal_i,
  input  logic [DW-1:0]  smp_i,
  input  logic [DIW-1:0] di_lim_i,
  input  logic [TW-1:0]  rate_up_i,
  input  logic [TW-1:0]  rate_dn_i,
  input  logic [TW-1:0]  neg_dly_i,
  input  logic [TW-1:0]  pos_dly_i,
  input  logic           below_thr_i,
  input  logic           below_hys_i,
  input  logic           above_thr_i,
  input  logic           above_hys_i,
  input  logic [DW-1:0]  ref_i,
  input  logic [DIW-1:0] di_i,
  input  logic           det_i,
  input  logic [TW-1:0]  rcnt_i,
  input  logic [TW-1:0]  ntmr_i,
  input  logic [TW-1:0]  ptmr_i,
  output logic [DW-1:0]  ref_o,
  output logic [DIW-1:0] di_o,
  output logic           det_o,
  output logic [TW-1:0]  rcnt_o,
  output logic [TW-1:0]  ntmr_o,
  output logic [TW-1:0]  ptmr_o
);
  logic [DIW:0] di_inc;
  logic [TW:0]  nt_inc, pt_inc, rc_inc;
  logic [TW-1:0] rate;
  logic up, dn, elig, neg_snap, pos_snap;

  always_comb begin
    di_inc = {1'b0, di_i} + 1'b1;
    nt_inc = {1'b0, ntmr_i} + 1'b1;
    pt_inc = {1'b0, ptmr_i} + 1'b1;
    rc_inc = {1'b0, rcnt_i} + 1'b1;
    ref_o  = ref_i;
    di_o   = di_i;
    det_o  = det_i;
    rcnt_o = rcnt_i;

    // confirmation integrator
    if (di_lim_i == '0) begin
      di_o  = '0;
      det_o = 1'b0;
    end else if (!det_i) begin
      if (below_thr_i) begin
        if (di_inc >= {1'b0, di_lim_i}) begin
          di_o  = di_lim_i;
          det_o = 1'b1;
        end else begin
          di_o = di_inc[DIW-1:0];
        end
      end else if (below_hys_i) begin
        di_o = (di_i != '0) ? di_i - 1'b1 : '0;
      end else begin
        di_o = '0;
      end
    end else begin
      if (below_hys_i) begin
        di_o = di_lim_i;
      end else if (di_i <= 1) begin
        di_o  = '0;
        det_o = 1'b0;
      end else begin
        di_o = di_i - 1'b1;
      end
    end

    // recalibration timers
    neg_snap = det_i && (neg_dly_i != '0) && (nt_inc >= {1'b0, neg_dly_i});
    ntmr_o   = (det_i && det_o) ? (nt_inc[TW] ? '1 : nt_inc[TW-1:0]) : '0;
    pos_snap = above_thr_i && (pos_dly_i != '0) && (pt_inc >= {1'b0, pos_dly_i});
    if (above_thr_i)      ptmr_o = pt_inc[TW] ? '1 : pt_inc[TW-1:0];
    else if (above_hys_i) ptmr_o = ptmr_i;
    else                  ptmr_o = '0;

    // drift, idle keys only
    up   = smp_i > ref_i;
    dn   = smp_i < ref_i;
    elig = !det_i && !det_o;
    rate = up ? rate_up_i : rate_dn_i;
    if (elig && (up || dn) && (rate != '0)) begin
      if (rc_inc >= {1'b0, rate}) begin
        rcnt_o = '0;
        ref_o  = up ? ref_i + 1'b1 : ref_i - 1'b1;
      end else begin
        rcnt_o = rc_inc[TW-1:0];
      end
    end

    if (cal_i || neg_snap || pos_snap) begin
      ref_o  = smp_i;
      di_o   = '0;
      det_o  = 1'b0;
      rcnt_o = '0;
      ntmr_o = '0;
      ptmr_o = '0;
    end
  end
endmodule

// File: rtl/touch_key_engine.sv
module touch_key_engine #(
  parameter int KEYS     = 64,
  parameter int DW       = 8,
  parameter int DIW      = 4,
  parameter int TW       = 8,
  parameter int REF_INIT = 128,
  parameter int ERR_HI   = 191,
  parameter int ERR_LO   = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic [$clog2(KEYS)-1:0] key_idx_i,
  input  logic [DW-1:0]           smp_i,
  input  logic                    cal_i,
  input  logic [DW-1:0]           neg_thr_i,
  input  logic [DW-1:0]           pos_thr_i,
  input  logic [1:0]              neg_hys_i,
  input  logic [1:0]              pos_hys_i,
  input  logic [DIW-1:0]          di_lim_i,
  input  logic [TW-1:0]           rate_up_i,
  input  logic [TW-1:0]           rate_dn_i,
  input  logic [TW-1:0]           neg_dly_i,
  input  logic [TW-1:0]           pos_dly_i,
  output logic [KEYS-1:0]         det_o,
  output logic [KEYS-1:0]         err_hi_o,
  output logic [KEYS-1:0]         err_lo_o,
  output logic [DW-1:0]           ref_o
);
  logic [DW-1:0]  ref_q  [KEYS];
  logic [DIW-1:0] di_q   [KEYS];
  logic [TW-1:0]  rcnt_q [KEYS];
  logic [TW-1:0]  ntmr_q [KEYS];
  logic [TW-1:0]  ptmr_q [KEYS];
  logic [KEYS-1:0] det_q;

  logic [DW-1:0]  ref_n;
  logic [DIW-1:0] di_n;
  logic [TW-1:0]  rcnt_n, ntmr_n, ptmr_n;
  logic det_n, b_thr, b_hys, a_thr, a_hys;

  tke_level #(.DW(DW)) u_level (
    .ref_i(ref_q[key_idx_i]), .smp_i(smp_i),
    .nthr_i(neg_thr_i), .pthr_i(pos_thr_i),
    .nhys_i(neg_hys_i), .phys_i(pos_hys_i),
    .below_thr_o(b_thr), .below_hys_o(b_hys),
    .above_thr_o(a_thr), .above_hys_o(a_hys)
  );

  tke_next #(.DW(DW), .DIW(DIW), .TW(TW)) u_next (
    .cal_i(cal_i), .smp_i(smp_i), .di_lim_i(di_lim_i),
    .rate_up_i(rate_up_i), .rate_dn_i(rate_dn_i),
    .neg_dly_i(neg_dly_i), .pos_dly_i(pos_dly_i),
    .below_thr_i(b_thr), .below_hys_i(b_hys),
    .above_thr_i(a_thr), .above_hys_i(a_hys),
    .ref_i(ref_q[key_idx_i]), .di_i(di_q[key_idx_i]), .det_i(det_q[key_idx_i]),
    .rcnt_i(rcnt_q[key_idx_i]), .ntmr_i(ntmr_q[key_idx_i]), .ptmr_i(ptmr_q[key_idx_i]),
    .ref_o(ref_n), .di_o(di_n), .det_o(det_n),
    .rcnt_o(rcnt_n), .ntmr_o(ntmr_n), .ptmr_o(ptmr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= '0;
      for (int i = 0; i < KEYS; i++) begin
        ref_q[i]  <= DW'(REF_INIT);
        di_q[i]   <= '0;
        rcnt_q[i] <= '0;
        ntmr_q[i] <= '0;
        ptmr_q[i] <= '0;
      end
    end else if (smp_vld_i) begin
      ref_q[key_idx_i]  <= ref_n;
      di_q[key_idx_i]   <= di_n;
      det_q[key_idx_i]  <= det_n;
      rcnt_q[key_idx_i] <= rcnt_n;
      ntmr_q[key_idx_i] <= ntmr_n;
      ptmr_q[key_idx_i] <= ptmr_n;
    end
  end

  for (genvar g = 0; g < KEYS; g++) begin : g_err
    assign err_hi_o[g] = ref_q[g] > DW'(ERR_HI);
    assign err_lo_o[g] = ref_q[g] < DW'(ERR_LO);
  end

  assign det_o = det_q;
  assign ref_o = ref_q[key_idx_i];
endmodule

// File: rtl/tke_chk.sv
module tke_chk #(
  parameter int KEYS = 64,
  parameter int DW   = 8,
  parameter int DIW  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_vld_i,
  input logic [$clog2(KEYS)-1:0] key_idx_i,
  input logic [DW-1:0]           smp_i,
  input logic                    cal_i,
  input logic [DW-1:0]           neg_thr_i,
  input logic [DIW-1:0]          di_lim_i,
  input logic [KEYS-1:0]         det_o,
  input logic [KEYS-1:0]         err_hi_o,
  input logic [KEYS-1:0]         err_lo_o,
  input logic [DW-1:0]           ref_o
);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(det_o) && $stable(err_hi_o) && $stable(err_lo_o));

  // R11
  one_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> $countones(det_o ^ $past(det_o)) <= 1);

  // R3
  no_shallow_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !det_o[key_idx_i] && ({1'b0, ref_o} < {1'b0, smp_i} + {1'b0, neg_thr_i})
    |=> !det_o[$past(key_idx_i)]);

  // R5
  lim_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && di_lim_i == '0 |=> !det_o[$past(key_idx_i)]);

  // R10
  cal_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && cal_i |=> !det_o[$past(key_idx_i)]);

  // R10
  cal_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && cal_i |=> (key_idx_i != $past(key_idx_i)) || (ref_o == $past(smp_i)));
endmodule

bind touch_key_engine tke_chk #(.KEYS(KEYS), .DW(DW), .DIW(DIW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .key_idx_i(key_idx_i),
  .smp_i(smp_i), .cal_i(cal_i), .neg_thr_i(neg_thr_i), .di_lim_i(di_lim_i),
  .det_o(det_o), .err_hi_o(err_hi_o), .err_lo_o(err_lo_o), .ref_o(ref_o)
);

// File: tb/touch_key_engine_tb.sv
module touch_key_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, cal = 1'b0;
  logic [5:0] idx = '0;
  logic [7:0] smp = '0, nthr, pthr, rup, rdn, ndly, pdly;
  logic [1:0] nhys, phys;
  logic [3:0] lim;
  logic [63:0] det, ehi, elo;
  logic [7:0] refv;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  touch_key_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .key_idx_i(idx), .smp_i(smp),
    .cal_i(cal), .neg_thr_i(nthr), .pos_thr_i(pthr), .neg_hys_i(nhys), .pos_hys_i(phys),
    .di_lim_i(lim), .rate_up_i(rup), .rate_dn_i(rdn), .neg_dly_i(ndly), .pos_dly_i(pdly),
    .det_o(det), .err_hi_o(ehi), .err_lo_o(elo), .ref_o(refv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    nthr = 8'd20; pthr = 8'd20; nhys = 2'd1; phys = 2'd1; lim = 4'd3;
    rup = 8'd0; rdn = 8'd0; ndly = 8'd0; pdly = 8'd0;
  endtask

  task automatic put(input int k, input int v, input bit c = 1'b0);
    @(negedge clk);
    idx = 6'(k); smp = 8'(v); cal = c; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; cal = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 det", det, 64'd0);
    chk("R1 err_hi", ehi, 64'd0);
    chk("R1 err_lo", elo, 64'd0);
    idx = 6'd40; #1;
    chk("R1 ref", 64'(refv), 64'd128);
  endtask

  task automatic t_confirm();
    defaults();
    put(3, 100); put(3, 100);
    chk("R3 not yet", 64'(det[3]), 0);
    put(3, 100);
    chk("R3 confirmed", 64'(det[3]), 1);
    chk("R11 only key3", det, 64'd1 << 3);
  endtask

  task automatic t_decrement();
    defaults();
    put(5, 100); put(5, 100); put(5, 111); put(5, 100);
    chk("R4 decrement", 64'(det[5]), 0);
    put(5, 100);
    chk("R4 after decrement", 64'(det[5]), 1);
  endtask

  task automatic t_clear();
    defaults();
    put(6, 100); put(6, 100); put(6, 120); put(6, 100); put(6, 100);
    chk("R4 clear", 64'(det[6]), 0);
    put(6, 100);
    chk("R4 after clear", 64'(det[6]), 1);
  endtask

  task automatic t_release();
    defaults();
    put(3, 112); put(3, 128); put(3, 128);
    chk("R5 hold", 64'(det[3]), 1);
    put(3, 128);
    chk("R5 release", 64'(det[3]), 0);
    chk("R2 ref kept", 64'(refv), 128);
  endtask

  task automatic t_lim_zero();
    defaults(); lim = 4'd0;
    for (int i = 0; i < 5; i++) put(7, 60);
    chk("R5 lim zero", 64'(det[7]), 0);
  endtask

  task automatic t_hys_code();
    // code 2 = 50%: band starts at d >= 10; d=12 decrements, d=8 clears
    defaults(); nhys = 2'd2;
    put(14, 100); put(14, 100); put(14, 116); put(14, 100);
    chk("R2 half band", 64'(det[14]), 0);
    put(14, 100);
    chk("R2 half band conf", 64'(det[14]), 1);
  endtask

  task automatic t_drift();
    defaults(); rup = 8'd2;
    for (int i = 0; i < 4; i++) put(8, 140);
    chk("R6 up", 64'(refv), 130);
    rup = 8'd0; rdn = 8'd3;
    for (int i = 0; i < 6; i++) put(8, 120);
    chk("R6 down", 64'(refv), 128);
    rdn = 8'd0;
    for (int i = 0; i < 4; i++) put(8, 140);
    chk("R6 disabled", 64'(refv), 128);
  endtask

  task automatic t_det_vs_drift();
    defaults(); rdn = 8'd1; lim = 4'd1;
    put(9, 100);
    chk("R6 conf cycle det", 64'(det[9]), 1);
    chk("R6 conf cycle ref", 64'(refv), 128);
    put(9, 100);
    chk("R6 detected ref", 64'(refv), 128);
  endtask

  task automatic t_neg_recal();
    defaults(); lim = 4'd1; ndly = 8'd3;
    put(10, 100); put(10, 100); put(10, 100);
    chk("R7 before", 64'(det[10]), 1);
    chk("R7 ref before", 64'(refv), 128);
    put(10, 100);
    chk("R7 snap det", 64'(det[10]), 0);
    chk("R7 snap ref", 64'(refv), 100);
  endtask

  task automatic t_pos_recal();
    defaults(); pdly = 8'd2;
    put(11, 150); put(11, 145);
    chk("R8 hold", 64'(refv), 128);
    put(11, 150);
    chk("R8 snap", 64'(refv), 150);
    put(15, 150); put(15, 130); put(15, 150);
    chk("R8 cleared", 64'(refv), 128);
  endtask

  task automatic t_errors();
    defaults(); pdly = 8'd1;
    put(12, 200);
    chk("R9 hi set", 64'(ehi[12]), 1);
    pdly = 8'd0;
    for (int i = 0; i < 3; i++) put(12, 200);
    chk("R9 no auto recal", 64'(refv), 200);
    put(12, 191, 1'b1);
    chk("R9 191", 64'(ehi[12]), 0);
    put(12, 192, 1'b1);
    chk("R9 192", 64'(ehi[12]), 1);
    put(12, 64, 1'b1);
    chk("R9 64", 64'(elo[12]), 0);
    put(12, 63, 1'b1);
    chk("R9 63 lo", 64'(elo[12]), 1);
    chk("R9 63 hi", 64'(ehi[12]), 0);
  endtask

  task automatic t_cal();
    defaults();
    put(13, 100); put(13, 100);
    put(13, 100, 1'b1);
    chk("R10 ref", 64'(refv), 100);
    put(13, 72); put(13, 72);
    chk("R10 count cleared", 64'(det[13]), 0);
    put(13, 72);
    chk("R10 detect", 64'(det[13]), 1);
    put(13, 90, 1'b1);
    chk("R10 det cleared", 64'(det[13]), 0);
    idx = 6'd10; #1;
    chk("R12 readout", 64'(refv), 100);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_confirm();
    t_decrement();
    t_clear();
    t_release();
    t_lim_zero();
    t_hys_code();
    t_drift();
    t_det_vs_drift();
    t_neg_recal();
    t_pos_recal();
    t_errors();
    t_cal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule